// File: doc/BRIEF.md
# Paged Multi-Memory Address Decoder

This block sits behind a 16-bit host bus and steers every word read and write into one of four on-chip 16-bit memories. The memories are a controller register file, a modulation memory, a normal-operation drive memory and a sequence memory. The two upper address bits choose the memory and the remaining bits form a word address inside a window of 2^(ADDR_W-2) words.

The modulation and sequence memories can be deeper than one window. Each has its own page register inside the controller register file. The page number is placed above the window address to form the effective word address. The page registers are ordinary controller words, so the host moves a window by writing one register and then accessing the window on the next cycle.

The controller register file also holds a version word, a minor-version word and a device-info word. Reset gives the version and minor words fixed values. Bit 0 of the device-info word follows an external thermal-sensor input. All memory depths are parameters. The full-size build uses CTRL_AW=10, MOD_AW=15, NORM_AW=9 and STM_AW=19. The defaults are kept small.

Top module: `mem_page_decoder`

## Requirements
- R1: The bank is selected by bus_addr[ADDR_W-1:ADDR_W-2]: 0 is the controller, 1 is modulation, 2 is normal drive and 3 is sequence. The same in-bank address in different banks reaches different storage.
- R2: When bus_re is high at a clock edge, bus_rdata shows the addressed word after that edge, with one cycle of latency. bus_rdata holds its value in every cycle that follows an edge at which bus_re was low, and writes do not change it.
- R3: After reset, the version word at controller address VER_ADDR reads {FEATURES, VER_MAJOR}, the minor word at MINOR_ADDR reads VER_MINOR, and both page registers read 0.
- R4: A modulation access goes to the word at effective address (modulation page register << (ADDR_W-2)) | in-bank address. The modulation page register is the controller word at MOD_PAGE_ADDR.
- R5: A sequence access goes to the word at effective address (sequence page register << (ADDR_W-2)) | in-bank address. The sequence page register is the controller word at STM_PAGE_ADDR and is separate from the modulation page register.
- R6: Controller and normal-drive accesses use the in-bank address directly and never use a page register. In-bank address bits above the bank's depth are ignored, so the address wraps within the bank.
- R7: A page-register write at one edge is used by a modulation or sequence access in the very next cycle.
- R8: Bit 0 of the device-info word at INFO_ADDR equals the thermal-sensor input sampled one edge earlier. A bus write to bit 0 has no effect. Bits 15:1 store written data.
- R9: Page-register bits that would extend the effective address past the bank's depth are ignored, so the page number wraps within the bank.
- R10: Storage changes only at an edge where bus_we is high. Setting up the address and data with bus_we low leaves every bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Bank select (top two bits) and in-bank word address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_re | input | 1 | Read strobe; data appears on bus_rdata one cycle later |
| thermal_in | input | 1 | Thermal-sensor level, mirrored into device-info bit 0 |
| bus_rdata | output | 16 | Registered read data |

## Verification
The assertions take four things for granted about the inputs. First, thermal_in is a clean synchronous level that is driven from time zero. Second, reset is held long enough for the two-cycle look-back on the thermal mirror to land inside driven values. Third, the version check counts only a read issued in the first cycle after reset is released. Fourth, the assertions assume a read never targets the word being written in the same cycle.

The bench uses a scaled configuration with an 8-bit window, so several pages and wrap cases fit in small memories. It drives every input at the falling edge. It holds thermal_in low through reset and changes it only between bus operations. It never issues a read and a write to the same word in one cycle.

// File: rtl/page_dec_pkg.sv
// Shared types and widths for the paged multi-memory decoder.
package page_dec_pkg;
    localparam int WORD_W     = 16;
    localparam int BANK_SEL_W = 2;
    localparam int NUM_BANKS  = 4;

    typedef enum logic [BANK_SEL_W-1:0] {
        BANK_CTRL = 2'd0,
        BANK_MOD  = 2'd1,
        BANK_NORM = 2'd2,
        BANK_STM  = 2'd3
    } bank_e;
endpackage

// File: rtl/word_ram.sv
// Single-port word memory with a synchronous write and a registered read.
// Assumes: one access per cycle. A read in the same cycle as a write to
// the same word returns the old contents. The read register clears on reset.
module word_ram #(
    parameter int AW = 9,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store the write data into the addressed word.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Capture the addressed word into the read register on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/page_extend.sv
// Forms a bank's effective word address from the in-window address.
// Paged banks place the page number above the window bits. Unpaged banks
// use the window address alone. Bits beyond AW are dropped, so the
// address wraps within the bank.
module page_extend #(
    parameter int WIN_W  = 14,
    parameter int PAGE_W = 16,
    parameter int AW     = 10,
    parameter bit PAGED  = 1'b0
) (
    input  logic [WIN_W-1:0]  win,
    input  logic [PAGE_W-1:0] page,
    output logic [AW-1:0]     eff
);
    localparam int FULL_W = PAGE_W + WIN_W;

    generate
        if (PAGED) begin : g_paged
            logic [FULL_W-1:0] full;
            logic              unused_full;
            // Join the page above the window and keep the bank's low bits.
            assign full        = {page, win};
            assign eff         = full[AW-1:0];
            assign unused_full = ^full;
        end else if (AW <= WIN_W) begin : g_trunc
            logic unused_in;
            // Keep only the window bits the bank can hold.
            assign eff       = win[AW-1:0];
            assign unused_in = ^{page, win};
        end else begin : g_zext
            logic unused_pg;
            // The bank is deeper than the window and has no page: zero-extend.
            assign eff       = {{(AW-WIN_W){1'b0}}, win};
            assign unused_pg = ^page;
        end
    endgenerate
endmodule

// File: rtl/ctrl_regs.sv
// Controller register file. It is a plain word array with dedicated
// registers laid over it for the version word, the minor-version word,
// the device-info word and the two page registers.
// Assumes: the special addresses are distinct and fit in CTRL_AW bits.
// thermal_in is already synchronous to clk.
module ctrl_regs #(
    parameter int         CTRL_AW       = 10,
    parameter int         VER_ADDR      = 0,
    parameter int         MINOR_ADDR    = 1,
    parameter int         INFO_ADDR     = 2,
    parameter int         MOD_PAGE_ADDR = 3,
    parameter int         STM_PAGE_ADDR = 4,
    parameter logic [7:0] FEATURES      = 8'h00,
    parameter logic [7:0] VER_MAJOR     = 8'h01,
    parameter logic [7:0] VER_MINOR     = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               re,
    input  logic [CTRL_AW-1:0] addr,
    input  logic [15:0]        wdata,
    input  logic               thermal_in,
    output logic [15:0]        rdata,
    output logic [15:0]        mod_page,
    output logic [15:0]        stm_page
);
    localparam logic [CTRL_AW-1:0] A_VER   = CTRL_AW'(VER_ADDR);
    localparam logic [CTRL_AW-1:0] A_MINOR = CTRL_AW'(MINOR_ADDR);
    localparam logic [CTRL_AW-1:0] A_INFO  = CTRL_AW'(INFO_ADDR);
    localparam logic [CTRL_AW-1:0] A_MPG   = CTRL_AW'(MOD_PAGE_ADDR);
    localparam logic [CTRL_AW-1:0] A_SPG   = CTRL_AW'(STM_PAGE_ADDR);
    localparam logic [15:0]        VER_RST = {FEATURES, VER_MAJOR};

    logic [15:0] ver_q, minor_q, mpg_q, spg_q;
    logic [14:0] info_hi_q;
    logic        info_lo_q;
    logic [15:0] plain_rd, rd_sel;

    word_ram #(.AW(CTRL_AW), .DW(16)) u_plain (
        .clk(clk), .rst_n(rst_n), .we(we), .re(re),
        .addr(addr), .wdata(wdata), .rdata(plain_rd)
    );

    // Dedicated registers: reset values, then host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ver_q     <= VER_RST;
            minor_q   <= {8'h00, VER_MINOR};
            mpg_q     <= '0;
            spg_q     <= '0;
            info_hi_q <= '0;
        end else if (we) begin
            if (addr == A_VER)   ver_q     <= wdata;
            if (addr == A_MINOR) minor_q   <= wdata;
            if (addr == A_MPG)   mpg_q     <= wdata;
            if (addr == A_SPG)   spg_q     <= wdata;
            if (addr == A_INFO)  info_hi_q <= wdata[15:1];
        end
    end

    // Mirror the thermal-sensor level into device-info bit 0 every cycle.
    always_ff @(posedge clk) begin
        info_lo_q <= thermal_in;
    end

    // Remember which source the pending read comes from.
    logic [2:0] src_q;
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 3'd0;
        else if (re) begin
            if      (addr == A_VER)   src_q <= 3'd1;
            else if (addr == A_MINOR) src_q <= 3'd2;
            else if (addr == A_INFO)  src_q <= 3'd3;
            else if (addr == A_MPG)   src_q <= 3'd4;
            else if (addr == A_SPG)   src_q <= 3'd5;
            else                      src_q <= 3'd0;
        end
    end

    // Capture the dedicated-register value at the read edge.
    logic [15:0] spec_q;
    always_ff @(posedge clk) begin
        if (!rst_n)  spec_q <= '0;
        else if (re) spec_q <= rd_sel;
    end

    // Select the current dedicated-register value for the read address.
    always_comb begin
        unique case (1'b1)
            addr == A_VER:   rd_sel = ver_q;
            addr == A_MINOR: rd_sel = minor_q;
            addr == A_INFO:  rd_sel = {info_hi_q, info_lo_q};
            addr == A_MPG:   rd_sel = mpg_q;
            addr == A_SPG:   rd_sel = spg_q;
            default:         rd_sel = '0;
        endcase
    end

    assign rdata    = (src_q == 3'd0) ? plain_rd : spec_q;
    assign mod_page = mpg_q;
    assign stm_page = spg_q;
endmodule

// File: rtl/mem_page_decoder.sv
// Top of the paged multi-memory decoder. It splits the bus address into
// a bank select and an in-window address, extends the modulation and
// sequence addresses with their page registers, gates the write strobes
// per bank and returns registered read data from the bank that was read.
// Assumes: at most one read and one write per cycle, which share bus_addr.
module mem_page_decoder
    import page_dec_pkg::*;
#(
    parameter int         ADDR_W        = 16,
    parameter int         CTRL_AW       = 10,
    parameter int         MOD_AW        = 11,
    parameter int         NORM_AW       = 9,
    parameter int         STM_AW        = 12,
    parameter int         VER_ADDR      = 0,
    parameter int         MINOR_ADDR    = 1,
    parameter int         INFO_ADDR     = 2,
    parameter int         MOD_PAGE_ADDR = 3,
    parameter int         STM_PAGE_ADDR = 4,
    parameter logic [7:0] FEATURES      = 8'h00,
    parameter logic [7:0] VER_MAJOR     = 8'h01,
    parameter logic [7:0] VER_MINOR     = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic              thermal_in,
    output logic [15:0]       bus_rdata
);
    localparam int WIN_W = ADDR_W - BANK_SEL_W;

    logic [BANK_SEL_W-1:0] sel;
    logic [WIN_W-1:0]      win;
    bank_e                 bank_q;
    logic [NUM_BANKS-1:0]  bank_we, bank_re;
    logic [15:0]           mod_page, stm_page;
    logic [CTRL_AW-1:0]    ctrl_addr;
    logic [MOD_AW-1:0]     mod_addr;
    logic [NORM_AW-1:0]    norm_addr;
    logic [STM_AW-1:0]     stm_addr;
    logic [15:0]           rd_ctrl, rd_mod, rd_norm, rd_stm;

    assign sel = bus_addr[ADDR_W-1 -: BANK_SEL_W];
    assign win = bus_addr[WIN_W-1:0];

    // One write and one read strobe per bank.
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_strobe
            assign bank_we[b] = bus_we && (sel == BANK_SEL_W'(b));
            assign bank_re[b] = bus_re && (sel == BANK_SEL_W'(b));
        end
    endgenerate

    page_extend #(.WIN_W(WIN_W), .PAGE_W(16), .AW(CTRL_AW), .PAGED(1'b0)) u_ext_ctrl (
        .win(win), .page(16'h0000), .eff(ctrl_addr));
    page_extend #(.WIN_W(WIN_W), .PAGE_W(16), .AW(MOD_AW), .PAGED(1'b1)) u_ext_mod (
        .win(win), .page(mod_page), .eff(mod_addr));
    page_extend #(.WIN_W(WIN_W), .PAGE_W(16), .AW(NORM_AW), .PAGED(1'b0)) u_ext_norm (
        .win(win), .page(16'h0000), .eff(norm_addr));
    page_extend #(.WIN_W(WIN_W), .PAGE_W(16), .AW(STM_AW), .PAGED(1'b1)) u_ext_stm (
        .win(win), .page(stm_page), .eff(stm_addr));

    ctrl_regs #(
        .CTRL_AW(CTRL_AW), .VER_ADDR(VER_ADDR), .MINOR_ADDR(MINOR_ADDR),
        .INFO_ADDR(INFO_ADDR), .MOD_PAGE_ADDR(MOD_PAGE_ADDR),
        .STM_PAGE_ADDR(STM_PAGE_ADDR), .FEATURES(FEATURES),
        .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(bank_we[BANK_CTRL]), .re(bank_re[BANK_CTRL]),
        .addr(ctrl_addr), .wdata(bus_wdata), .thermal_in(thermal_in),
        .rdata(rd_ctrl), .mod_page(mod_page), .stm_page(stm_page)
    );

    word_ram #(.AW(MOD_AW), .DW(16)) u_mod (
        .clk(clk), .rst_n(rst_n), .we(bank_we[BANK_MOD]), .re(bank_re[BANK_MOD]),
        .addr(mod_addr), .wdata(bus_wdata), .rdata(rd_mod));
    word_ram #(.AW(NORM_AW), .DW(16)) u_norm (
        .clk(clk), .rst_n(rst_n), .we(bank_we[BANK_NORM]), .re(bank_re[BANK_NORM]),
        .addr(norm_addr), .wdata(bus_wdata), .rdata(rd_norm));
    word_ram #(.AW(STM_AW), .DW(16)) u_stm (
        .clk(clk), .rst_n(rst_n), .we(bank_we[BANK_STM]), .re(bank_re[BANK_STM]),
        .addr(stm_addr), .wdata(bus_wdata), .rdata(rd_stm));

    // Remember which bank the last read went to.
    always_ff @(posedge clk) begin
        if (!rst_n)      bank_q <= BANK_CTRL;
        else if (bus_re) bank_q <= bank_e'(sel);
    end

    // Return the registered word of the bank that was read.
    always_comb begin
        unique case (bank_q)
            BANK_CTRL: bus_rdata = rd_ctrl;
            BANK_MOD:  bus_rdata = rd_mod;
            BANK_NORM: bus_rdata = rd_norm;
            BANK_STM:  bus_rdata = rd_stm;
            default:   bus_rdata = rd_ctrl;
        endcase
    end
endmodule

// File: rtl/page_dec_checker.sv
// Protocol and decode properties for mem_page_decoder, bound to each instance.
// Assumes: thermal_in is driven from time zero and reset lasts at least two cycles.
module page_dec_checker #(
    parameter int         ADDR_W        = 16,
    parameter int         CTRL_AW       = 10,
    parameter int         VER_ADDR      = 0,
    parameter int         INFO_ADDR     = 2,
    parameter int         MOD_PAGE_ADDR = 3,
    parameter int         STM_PAGE_ADDR = 4,
    parameter logic [7:0] FEATURES      = 8'h00,
    parameter logic [7:0] VER_MAJOR     = 8'h01
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic              thermal_in,
    input logic [15:0]       bus_rdata,
    input logic [3:0]        bank_we,
    input logic [15:0]       mod_page,
    input logic [15:0]       stm_page
);
    logic ctrl_hit;
    assign ctrl_hit = (bus_addr[ADDR_W-1 -: 2] == 2'd0);

    p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_re) |-> $stable(bus_rdata));

    p_version_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && bus_re && ctrl_hit && bus_addr[CTRL_AW-1:0] == CTRL_AW'(VER_ADDR))
        |=> bus_rdata == {FEATURES, VER_MAJOR});

    p_mod_page_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ctrl_hit && bus_addr[CTRL_AW-1:0] == CTRL_AW'(MOD_PAGE_ADDR))
        |=> mod_page == $past(bus_wdata));

    p_stm_page_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ctrl_hit && bus_addr[CTRL_AW-1:0] == CTRL_AW'(STM_PAGE_ADDR))
        |=> stm_page == $past(bus_wdata));

    p_thermal_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && ctrl_hit && bus_addr[CTRL_AW-1:0] == CTRL_AW'(INFO_ADDR))
        |=> bus_rdata[0] == $past(thermal_in, 2));

    p_we_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |-> bank_we == 4'b0000);
endmodule

bind mem_page_decoder page_dec_checker #(
    .ADDR_W(ADDR_W), .CTRL_AW(CTRL_AW), .VER_ADDR(VER_ADDR), .INFO_ADDR(INFO_ADDR),
    .MOD_PAGE_ADDR(MOD_PAGE_ADDR), .STM_PAGE_ADDR(STM_PAGE_ADDR),
    .FEATURES(FEATURES), .VER_MAJOR(VER_MAJOR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .thermal_in(thermal_in),
    .bus_rdata(bus_rdata), .bank_we(bank_we), .mod_page(mod_page),
    .stm_page(stm_page)
);

// File: tb/tb_mem_page_decoder.sv
// Bench for mem_page_decoder in a scaled configuration with an 8-bit window.
// Banks: controller 64 words, modulation 4 pages, normal 32 words, sequence 8 pages.
module tb_mem_page_decoder;
    localparam int ADDR_W = 10;
    localparam logic [7:0] FEAT = 8'hA5, MAJ = 8'h0C, MINR = 8'h03;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic              bus_we = 1'b0, bus_re = 1'b0, thermal_in = 1'b0;
    logic [15:0]       bus_rdata;

    int n_checks = 0, n_fail = 0;

    always #2 clk = ~clk;

    mem_page_decoder #(
        .ADDR_W(ADDR_W), .CTRL_AW(6), .MOD_AW(10), .NORM_AW(5), .STM_AW(11),
        .VER_ADDR(0), .MINOR_ADDR(1), .INFO_ADDR(2), .MOD_PAGE_ADDR(3),
        .STM_PAGE_ADDR(4), .FEATURES(FEAT), .VER_MAJOR(MAJ), .VER_MINOR(MINR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .thermal_in(thermal_in),
        .bus_rdata(bus_rdata)
    );

    // Vector fields: [29:26] page, [25:24] bank, [23:16] window address, [15:0] data.
    localparam logic [29:0] VEC [8] = '{
        {4'd0, 2'd0, 8'h10, 16'h1111},
        {4'd0, 2'd1, 8'h05, 16'h2222},
        {4'd3, 2'd1, 8'h05, 16'h3333},
        {4'd0, 2'd2, 8'h07, 16'h4444},
        {4'd0, 2'd3, 8'h05, 16'h5555},
        {4'd7, 2'd3, 8'hFF, 16'h6666},
        {4'd2, 2'd3, 8'h05, 16'h7777},
        {4'd1, 2'd1, 8'hFF, 16'h8888}
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Both tasks start at a falling edge and return at the next one.
    task automatic bus_write(input logic [1:0] bank, input logic [7:0] a, input logic [15:0] d);
        bus_addr = {bank, a}; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] bank, input logic [7:0] a, output logic [15:0] d);
        bus_addr = {bank, a}; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_page(input logic [1:0] bank, input logic [3:0] pg);
        if (bank == 2'd1) bus_write(2'd0, 8'd3, {12'h000, pg});
        if (bank == 2'd3) bus_write(2'd0, 8'd4, {12'h000, pg});
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        repeat (5) @(negedge clk);
        check("R2 rdata cleared in reset", bus_rdata, 16'h0000);
        rst_n = 1'b1;
        // R3 reset values
        bus_read(2'd0, 8'd0, rd); check("R3 version word", rd, {FEAT, MAJ});
        bus_read(2'd0, 8'd1, rd); check("R3 minor word", rd, {8'h00, MINR});
        bus_read(2'd0, 8'd3, rd); check("R3 mod page reset", rd, 16'h0000);
        bus_read(2'd0, 8'd4, rd); check("R3 seq page reset", rd, 16'h0000);

        // Vector walk: write all entries, then read them all back (R1, R4, R5)
        for (int i = 0; i < 8; i++) begin
            set_page(VEC[i][25:24], VEC[i][29:26]);
            bus_write(VEC[i][25:24], VEC[i][23:16], VEC[i][15:0]);
        end
        for (int i = 0; i < 8; i++) begin
            set_page(VEC[i][25:24], VEC[i][29:26]);
            bus_read(VEC[i][25:24], VEC[i][23:16], rd);
            check($sformatf("R1 R4 R5 vector %0d", i), rd, VEC[i][15:0]);
        end

        // R7: a page write followed at once by a read in the next cycle
        bus_write(2'd0, 8'd3, 16'h0000);
        bus_read(2'd1, 8'h05, rd); check("R7 mod page 0 next cycle", rd, 16'h2222);
        bus_write(2'd0, 8'd4, 16'h0002);
        bus_read(2'd3, 8'h05, rd); check("R7 seq page 2 next cycle", rd, 16'h7777);

        // R9: page bits above the bank depth wrap
        bus_write(2'd0, 8'd3, 16'h0005);
        bus_read(2'd1, 8'hFF, rd); check("R9 mod page 5 wraps to 1", rd, 16'h8888);
        bus_write(2'd0, 8'd4, 16'h000F);
        bus_read(2'd3, 8'hFF, rd); check("R9 seq page 15 wraps to 7", rd, 16'h6666);

        // R6: unpaged banks wrap within depth and ignore page registers
        bus_read(2'd2, 8'h27, rd); check("R6 normal wraps 0x27 to 0x07", rd, 16'h4444);
        bus_read(2'd0, 8'h50, rd); check("R6 ctrl wraps 0x50 to 0x10", rd, 16'h1111);

        // R10: address and data set up with the write strobe low
        bus_addr = {2'd2, 8'h07}; bus_wdata = 16'hDEAD; bus_we = 1'b0;
        @(negedge clk);
        bus_read(2'd2, 8'h07, rd); check("R10 no write with we low", rd, 16'h4444);

        // R2: read data holds through idle cycles and a write
        bus_write(2'd2, 8'h08, 16'h9999);
        repeat (2) @(negedge clk);
        check("R2 rdata held", bus_rdata, 16'h4444);
        bus_read(2'd2, 8'h08, rd); check("R2 one-cycle read of new word", rd, 16'h9999);

        // R8: thermal mirror in device-info bit 0
        thermal_in = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(2'd0, 8'd2, rd); check("R8 info bit0 set", rd, 16'h0001);
        bus_write(2'd0, 8'd2, 16'hFFFE);
        bus_read(2'd0, 8'd2, rd); check("R8 info upper bits stored", rd, 16'hFFFF);
        thermal_in = 1'b0;
        repeat (2) @(negedge clk);
        bus_read(2'd0, 8'd2, rd); check("R8 info bit0 cleared", rd, 16'hFFFE);
        bus_write(2'd0, 8'd2, 16'h0001);
        bus_read(2'd0, 8'd2, rd); check("R8 write to bit0 ignored", rd, 16'h0000);

        finish_run();
    end
endmodule